// File: doc/BRIEF.md
# Fetch Address Remap and Dual-Port Refill Router

This unit sits in front of an instruction cache's refill logic. Each cache-line refill request carries a fetch address. The unit first checks the address against four programmable alias windows. When a window matches, the unit rewrites the address onto that window's target base, so code held in an aliased memory can be executed through the code address space. Each window also sets whether its refill uses an incrementing burst or a wrapping burst of one line.

After translation, the unit compares the address with a programmable external-memory range. It then hands the refill to one of two independent master ports. The fast port serves internal flash and SRAM, and the slow port serves external memory. Each port holds at most one refill at a time. A long external refill therefore never stalls a refill on the fast port.

The configuration arrives as static input vectors from the surrounding control logic. A request is taken when `req_valid` and `req_ready` are both high on a clock edge.

Top module: `fetch_remap_router`

## Requirements
- R1: After a synchronous active-low reset, both ports are idle: `fast_req`, `slow_req`, `fast_busy` and `slow_busy` are all 0.
- R2: A window matches when the address bits outside its mask equal the same bits of its base. For a matching address, the outgoing address is the target's bits outside the mask joined with the input's bits inside the mask.
- R3: When several enabled windows match, the lowest-numbered one decides both the translation and the burst type.
- R4: A window whose enable bit is 0 never matches, whatever its base and mask.
- R5: An address that matches no enabled window passes through untranslated and is refilled with a wrapping burst.
- R6: For a wrapping burst the port drives `*_wrap`=1 and a word-aligned start address (bits 1:0 cleared), so the critical word comes first. For an incrementing burst it drives `*_wrap`=0 and a line-aligned start address (low log2(LINE_BYTES) bits cleared).
- R7: A translated address in the inclusive range `ext_lo`..`ext_hi` goes to the slow port. Any other address goes to the fast port. Exactly one port takes each accepted request.
- R8: Each port holds one refill. While the selected port is busy, `req_ready` is 0. A port keeps `*_req` high, with address and burst type stable, until `*_gnt` is seen, and then drops `*_req`.
- R9: A busy slow port does not lower `req_ready` for a request routed to the fast port, and the fast refill can finish while the slow one is still pending.
- R10: A `*_done` pulse while a port waits for its refill returns that port to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_en | input | NWIN | Enable bit for each alias window |
| win_base | input | NWIN x AW | Base address of each window |
| win_mask | input | NWIN x AW | Offset mask of each window (size minus one) |
| win_target | input | NWIN x AW | Target base of each window |
| win_incr | input | NWIN | 1 selects an incrementing burst for the window |
| ext_lo | input | AW | Lowest external-memory address |
| ext_hi | input | AW | Highest external-memory address |
| req_valid | input | 1 | Refill request present |
| req_addr | input | AW | Fetch address of the refill |
| req_ready | output | 1 | Selected port can take the request |
| fast_req | output | 1 | Fast port request |
| fast_addr | output | AW | Fast port burst start address |
| fast_wrap | output | 1 | Fast port wrapping burst |
| fast_gnt | input | 1 | Fast port grant |
| fast_done | input | 1 | Fast port refill finished |
| fast_busy | output | 1 | Fast port holds a refill |
| slow_req | output | 1 | Slow port request |
| slow_addr | output | AW | Slow port burst start address |
| slow_wrap | output | 1 | Slow port wrapping burst |
| slow_gnt | input | 1 | Slow port grant |
| slow_done | input | 1 | Slow port refill finished |
| slow_busy | output | 1 | Slow port holds a refill |

## Verification
A wrong window match or a wrong priority decode shows up within one cycle of acceptance, because the port request then carries a wrong start address or burst type. A routing fault puts the request on the wrong port, and the scoreboard queue of the other port sees a request it did not expect. A busy flag stuck high, or shared between the ports, shows as `req_ready` held low or as a fast refill that cannot finish while a slow refill is pending. This becomes visible within the latency of one refill.

// File: rtl/fr_pkg.sv
// Package: shared types for the fetch remap router.
// Assumes: nothing beyond IEEE 1800-2017.
package fr_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_REQ  = 2'd1,
        PS_WAIT = 2'd2
    } port_state_t;

    localparam int PORT_FAST = 0;
    localparam int PORT_SLOW = 1;
    localparam int NPORT     = 2;

endpackage

// File: rtl/fr_remap.sv
// Module: fr_remap
// Purpose: matches a fetch address against NWIN alias windows and translates it.
//          The lowest-numbered enabled match wins.
// Assumes: each mask is a contiguous low-order field (window size minus one).
//          The output is purely combinational.
module fr_remap #(
    parameter int AW   = 32,
    parameter int NWIN = 4
) (
    input  logic [AW-1:0]           in_addr,
    input  logic [NWIN-1:0]         win_en,
    input  logic [NWIN-1:0][AW-1:0] win_base,
    input  logic [NWIN-1:0][AW-1:0] win_mask,
    input  logic [NWIN-1:0][AW-1:0] win_target,
    input  logic [NWIN-1:0]         win_incr,
    output logic [AW-1:0]           out_addr,
    output logic                    out_incr,
    output logic                    out_hit,
    output logic [AW-1:0]           out_mask
);

    logic [NWIN-1:0]         hit_vec;
    logic [NWIN-1:0][AW-1:0] xlat;

    // One comparator and one translator for each window.
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign hit_vec[w] = win_en[w] &&
            ((in_addr & ~win_mask[w]) == (win_base[w] & ~win_mask[w]));
        assign xlat[w] = (win_target[w] & ~win_mask[w]) | (in_addr & win_mask[w]);
    end

    // Priority select: scan from the top so that the lowest index is applied last.
    always_comb begin
        out_addr = in_addr;
        out_incr = 1'b0;
        out_hit  = 1'b0;
        out_mask = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                out_addr = xlat[w];
                out_incr = win_incr[w];
                out_hit  = 1'b1;
                out_mask = win_mask[w];
            end
        end
    end

endmodule

// File: rtl/fr_port.sv
// Module: fr_port
// Purpose: one refill master port with a single outstanding request.
//          IDLE -> REQ on accept, REQ -> WAIT on grant, WAIT -> IDLE on done.
// Assumes: accept is raised only while busy is low. A done pulse outside WAIT is ignored.
module fr_port #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_wrap,
    input  logic          gnt,
    input  logic          done,
    output logic          m_req,
    output logic [AW-1:0] m_addr,
    output logic          m_wrap,
    output logic          busy
);
    import fr_pkg::*;

    port_state_t   state;
    logic [AW-1:0] addr_q;
    logic          wrap_q;

    // Port state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            case (state)
                PS_IDLE: if (accept) state <= PS_REQ;
                PS_REQ:  if (gnt)    state <= PS_WAIT;
                PS_WAIT: if (done)   state <= PS_IDLE;
                default:             state <= PS_IDLE;
            endcase
        end
    end

    // Capture the burst start address and burst type on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wrap_q <= 1'b0;
        end else if (accept && state == PS_IDLE) begin
            addr_q <= acc_addr;
            wrap_q <= acc_wrap;
        end
    end

    assign m_req  = (state == PS_REQ);
    assign m_addr = addr_q;
    assign m_wrap = wrap_q;
    assign busy   = (state != PS_IDLE);

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (state == PS_IDLE)); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !gnt) |=> (m_req && $stable(m_addr) && $stable(m_wrap))); // R8
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && gnt) |=> !m_req); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAIT && done) |=> !busy); // R10

endmodule

// File: rtl/fetch_remap_router.sv
// Module: fetch_remap_router (top)
// Purpose: translates refill addresses through alias windows, picks the burst
//          type and start address, and routes each refill to a fast or a slow port.
// Assumes: the configuration inputs are quasi-static. LINE_BYTES is a power of two, at least 4.
module fetch_remap_router #(
    parameter int AW         = 32,
    parameter int NWIN       = 4,
    parameter int LINE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NWIN-1:0]         win_en,
    input  logic [NWIN-1:0][AW-1:0] win_base,
    input  logic [NWIN-1:0][AW-1:0] win_mask,
    input  logic [NWIN-1:0][AW-1:0] win_target,
    input  logic [NWIN-1:0]         win_incr,
    input  logic [AW-1:0]           ext_lo,
    input  logic [AW-1:0]           ext_hi,
    input  logic                    req_valid,
    input  logic [AW-1:0]           req_addr,
    output logic                    req_ready,
    output logic                    fast_req,
    output logic [AW-1:0]           fast_addr,
    output logic                    fast_wrap,
    input  logic                    fast_gnt,
    input  logic                    fast_done,
    output logic                    fast_busy,
    output logic                    slow_req,
    output logic [AW-1:0]           slow_addr,
    output logic                    slow_wrap,
    input  logic                    slow_gnt,
    input  logic                    slow_done,
    output logic                    slow_busy
);
    import fr_pkg::*;

    localparam int LINE_LSB = $clog2(LINE_BYTES);

    logic [AW-1:0] rm_addr, rm_mask, start_addr;
    logic          rm_incr, rm_hit, sel_slow;

    logic [NPORT-1:0]         p_accept, p_gnt, p_done, p_req, p_wrap, p_busy;
    logic [NPORT-1:0][AW-1:0] p_addr;

    fr_remap #(.AW(AW), .NWIN(NWIN)) u_remap (
        .in_addr    (req_addr),
        .win_en     (win_en),
        .win_base   (win_base),
        .win_mask   (win_mask),
        .win_target (win_target),
        .win_incr   (win_incr),
        .out_addr   (rm_addr),
        .out_incr   (rm_incr),
        .out_hit    (rm_hit),
        .out_mask   (rm_mask)
    );

    // Burst start: line-aligned for incrementing, word-aligned (critical word) for wrapping.
    always_comb begin
        if (rm_incr) start_addr = {rm_addr[AW-1:LINE_LSB], {LINE_LSB{1'b0}}};
        else         start_addr = {rm_addr[AW-1:2], 2'b00};
    end

    // Port choice from the translated address against the external range.
    assign sel_slow  = (rm_addr >= ext_lo) && (rm_addr <= ext_hi);
    assign req_ready = sel_slow ? !p_busy[PORT_SLOW] : !p_busy[PORT_FAST];

    assign p_gnt  = {slow_gnt, fast_gnt};
    assign p_done = {slow_done, fast_done};

    // One independent port engine per master.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign p_accept[p] = req_valid && req_ready &&
                             (sel_slow == (p == PORT_SLOW));
        fr_port #(.AW(AW)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .accept   (p_accept[p]),
            .acc_addr (start_addr),
            .acc_wrap (!rm_incr),
            .gnt      (p_gnt[p]),
            .done     (p_done[p]),
            .m_req    (p_req[p]),
            .m_addr   (p_addr[p]),
            .m_wrap   (p_wrap[p]),
            .busy     (p_busy[p])
        );
    end

    assign fast_req  = p_req[PORT_FAST];
    assign fast_addr = p_addr[PORT_FAST];
    assign fast_wrap = p_wrap[PORT_FAST];
    assign fast_busy = p_busy[PORT_FAST];
    assign slow_req  = p_req[PORT_SLOW];
    assign slow_addr = p_addr[PORT_SLOW];
    assign slow_wrap = p_wrap[PORT_SLOW];
    assign slow_busy = p_busy[PORT_SLOW];

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_accept)); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rm_hit) |-> ((rm_addr & rm_mask) == (req_addr & rm_mask))); // R2
    AST_MISS_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rm_hit) |-> (!rm_incr && rm_addr == req_addr)); // R5
    AST_ACCEPT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (fast_busy || slow_busy)); // R8

endmodule

// File: tb/sim_fetch_remap_router.sv
module sim_fetch_remap_router;
    localparam int AW = 32, NW = 4, LB = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic rst_n;
    logic [NW-1:0]         win_en, win_incr;
    logic [NW-1:0][AW-1:0] win_base, win_mask, win_target;
    logic [AW-1:0]         ext_lo, ext_hi, req_addr;
    logic req_valid, req_ready;
    logic fast_req, fast_wrap, fast_gnt, fast_done, fast_busy;
    logic slow_req, slow_wrap, slow_gnt, slow_done, slow_busy;
    logic [AW-1:0] fast_addr, slow_addr;

    fetch_remap_router #(.AW(AW), .NWIN(NW), .LINE_BYTES(LB)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    int f_gdly = 0, s_gdly = 0, f_lat = 2, s_lat = 2, f_dones = 0;

    typedef struct { logic [AW-1:0] a; logic w; string tag; } exp_t;
    exp_t qf[$], qs[$];

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic [AW-1:0] a, output logic slow, output logic [AW-1:0] oa, output logic w);
        logic [AW-1:0] t;
        logic incr;
        logic found;
        t = a; incr = 1'b0; found = 1'b0;
        for (int i = 0; i < NW; i++) begin
            if (!found && win_en[i] && ((a & ~win_mask[i]) == (win_base[i] & ~win_mask[i]))) begin
                t = (win_target[i] & ~win_mask[i]) | (a & win_mask[i]);
                incr = win_incr[i];
                found = 1'b1;
            end
        end
        slow = (t >= ext_lo) && (t <= ext_hi);
        w = !incr;
        oa = incr ? (t & ~AW'(LB - 1)) : (t & ~AW'(3));
    endtask

    // Driver: push the expected item, then present the request until it is accepted.
    task automatic issue(input logic [AW-1:0] a, input string tag);
        logic s, w;
        logic [AW-1:0] oa;
        exp_t e;
        model(a, s, oa, w);
        e.a = oa; e.w = w; e.tag = tag;
        if (s) qs.push_back(e); else qf.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        #1;
        while (fast_busy || slow_busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Fast port monitor and responder.
    initial begin
        exp_t e;
        fast_gnt = 1'b0; fast_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && fast_req) begin
                if (qf.size() == 0) chk("R7 unexpected fast request", 1, 0);
                else begin
                    e = qf.pop_front();
                    chk({e.tag, " fast addr"}, fast_addr, e.a);
                    chk({e.tag, " fast wrap"}, AW'(fast_wrap), AW'(e.w));
                end
                for (int i = 0; i < f_gdly; i++) begin
                    @(negedge clk);
                    chk("R8 fast req held", AW'(fast_req), 1);
                    chk("R8 fast addr held", fast_addr, e.a);
                end
                fast_gnt = 1'b1;
                @(negedge clk);
                fast_gnt = 1'b0;
                chk("R8 fast req dropped", AW'(fast_req), 0);
                repeat (f_lat) @(negedge clk);
                fast_done = 1'b1;
                @(negedge clk);
                fast_done = 1'b0;
                f_dones++;
            end
        end
    end

    // Slow port monitor and responder.
    initial begin
        exp_t e;
        slow_gnt = 1'b0; slow_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && slow_req) begin
                if (qs.size() == 0) chk("R7 unexpected slow request", 1, 0);
                else begin
                    e = qs.pop_front();
                    chk({e.tag, " slow addr"}, slow_addr, e.a);
                    chk({e.tag, " slow wrap"}, AW'(slow_wrap), AW'(e.w));
                end
                for (int i = 0; i < s_gdly; i++) @(negedge clk);
                slow_gnt = 1'b1;
                @(negedge clk);
                slow_gnt = 1'b0;
                repeat (s_lat) @(negedge clk);
                slow_done = 1'b1;
                @(negedge clk);
                slow_done = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int k;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
        ext_lo = 32'h9000_0000; ext_hi = 32'h9FFF_FFFF;
        win_en     = 4'b1011;
        win_incr   = 4'b0010;
        win_base   = {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h2000_0000};
        win_mask   = {32'h0000_0FFF, 32'h0000_FFFF, 32'h000F_FFFF, 32'h0000_FFFF};
        win_target = {32'h9800_0000, 32'h0100_0000, 32'h9000_0000, 32'h0800_0000};
        repeat (3) @(negedge clk);
        chk("R1 fast_req at reset", AW'(fast_req), 0);
        chk("R1 slow_req at reset", AW'(slow_req), 0);
        chk("R1 busy at reset", AW'({fast_busy, slow_busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", AW'({fast_busy, slow_busy}), 0);

        issue(32'h2000_1236, "R3 R2 R6 overlap low window"); wait_idle();
        issue(32'h2001_0047, "R2 R6 R7 incr window"); wait_idle();
        issue(32'h3000_1234, "R4 disabled window"); wait_idle();
        issue(32'h4000_0ABC, "R2 R7 slow wrap window"); wait_idle();
        issue(32'h9100_0010, "R5 R7 passthrough slow"); wait_idle();
        issue(32'h0000_2003, "R5 passthrough fast"); wait_idle();

        // R8: grant held off on the fast port.
        f_gdly = 3;
        issue(32'h0800_0044, "R8 delayed grant"); wait_idle();
        f_gdly = 0;

        // R9: slow refill pending while a fast refill completes.
        s_lat = 40;
        issue(32'h4000_0100, "R9 slow pending");
        k = f_dones;
        issue(32'h3000_0200, "R9 fast while slow busy");
        #1;
        while (f_dones == k) @(negedge clk);
        @(negedge clk);
        chk("R10 fast idle after done", AW'(fast_busy), 0);
        chk("R9 slow still busy", AW'(slow_busy), 1);

        // R8: a second slow request is refused while the slow port is busy.
        req_valid = 1'b1; req_addr = 32'h9200_0000;
        #1;
        chk("R8 ready low for busy slow port", AW'(req_ready), 0);
        @(negedge clk);
        chk("R8 still refused", AW'(req_ready), 0);
        req_addr = 32'h0000_4000;
        #1;
        chk("R9 ready high for fast port", AW'(req_ready), 1);
        req_valid = 1'b0;
        wait_idle();
        s_lat = 2;

        // R3 and R4: disable window 0, so window 1 now decodes the same address.
        win_en[0] = 1'b0;
        issue(32'h2000_1236, "R4 R3 window0 off"); wait_idle();

        chk("R7 fast queue drained", AW'(qf.size()), 0);
        chk("R7 slow queue drained", AW'(qs.size()), 0);
        finish_run();
    end

endmodule